// File: doc/BRIEF.md
# Packing DMA Channel Buffer

This block sits between a 32-bit register/DMA access port and a sample-oriented audio stream. Words written by the bus land in a transmit FIFO and leave toward the stream one sample per handshake. Samples arriving from the stream collect in a receive FIFO, and the bus reads them back as words. When packing is enabled, a 32-bit bus word carries two 16-bit samples or four 8-bit samples. The transmit side splits each word into samples, and the receive side assembles samples into words.

Software sets the channel up through a control register. It holds an enable per direction, a loopback switch, a request threshold per direction, and a pack enable and pack mode per direction. A clear register gives each direction its own soft reset, which acts once and is not stored. A status register reports free space in both FIFOs and two trigger bits. The triggers also drive the two DMA request outputs. With loopback on, samples leaving the transmit side go straight into the receive side. The stream pins are then idle.

Bus writes and reads are single-cycle strobes. Read data appears on `bus_rdata` in the cycle after the read strobe.

Top module: `pack_dma_chan`

## Requirements
- R1: Control register at offset 0x00. Bit 31 is transmit enable, bit 30 receive enable, bit 29 loopback. Bits [23:16] hold the transmit threshold and bits [15:8] the receive threshold. Bit 6 is transmit pack enable with the transmit pack mode in [5:4]. Bit 2 is receive pack enable with the receive pack mode in [1:0]. Reads return the written value masked to these fields (mask 0xE0FFFF77).
- R2: Words written to offset 0x0C leave the stream in write order. With pack enable clear, or with a pack mode other than 2 or 3, each word leaves as one full 32-bit sample.
- R3: With transmit pack enable set and mode 3, each word leaves as two 16-bit samples, bits [15:0] first. Samples are zero-extended to 32 bits, and a stalled sample holds its value.
- R4: With transmit pack enable set and mode 2, each word leaves as four 8-bit samples, bits [7:0] first, each zero-extended.
- R5: On receive, the first sample of a word fills the lowest lane. Mode 3 with pack enable places the low 16 bits of two samples. Mode 2 places the low 8 bits of four samples. Otherwise each sample is stored as one whole word. Finished words are read at offset 0x10 in arrival order.
- R6: With loopback set, transmit samples go into the receive path. `strm_tx_valid` and `strm_rx_ready` stay low.
- R7: The status register at offset 0x08 reports (DEPTH minus transmit fill) in [31:24] and (DEPTH minus receive fill) in [23:16].
- R8: Status bit 1 and `tx_dma_req` are high when transmit free space is at least the transmit threshold. Status bit 0 and `rx_dma_req` are high when the receive fill is at least the receive threshold.
- R9: A write to offset 0x04 with bit 31 set empties the transmit FIFO and drops any partly sent word. With bit 30 set it empties the receive FIFO and drops any partly packed word. Either action takes one cycle, leaves the control register and the other direction untouched, and is not stored.
- R10: A data write to a full transmit FIFO is dropped. A read of an empty receive FIFO returns zero and changes nothing. A full receive FIFO holds `strm_rx_ready` low.
- R11: With transmit enable clear, no sample is offered and queued words stay queued. With receive enable clear, `strm_rx_ready` is low and no sample is taken.
- R12: After reset the control register is zero, both FIFOs are empty, the status reads 0x10100003 at the default depth of 16, and both stream handshake outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| strm_tx_valid | output | 1 | Transmit sample offered to the stream |
| strm_tx_ready | input | 1 | Stream accepts the transmit sample |
| strm_tx_data | output | 32 | Transmit sample, zero-extended |
| strm_rx_valid | input | 1 | Receive sample offered by the stream |
| strm_rx_ready | output | 1 | Block accepts the receive sample |
| strm_rx_data | input | 32 | Receive sample |
| tx_dma_req | output | 1 | Transmit request (free space at or above threshold) |
| rx_dma_req | output | 1 | Receive request (fill at or above threshold) |

## Verification
The assertions assume that `bus_wr` and `bus_rd` never rise in the same cycle. They also assume that the pack mode of a direction does not change while a word is partly sent or partly assembled. The output-hold property depends on that second assumption. The stimulus rewrites the control register only when the transmit side has nothing held and the receive side sits on a word boundary, using a soft reset where needed. The bench sweeps every fill level from empty to full against several thresholds in both directions.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CLEAR = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_TXD   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_RXD   = 5'h10;

  typedef enum logic [1:0] {
    PK_NONE = 2'd0,
    PK_RSV  = 2'd1,
    PK_BYTE = 2'd2,
    PK_HALF = 2'd3
  } pack_mode_e;

  typedef struct packed {
    logic       tx_en;
    logic       rx_en;
    logic       loopback;
    logic [7:0] tx_thr;
    logic [7:0] rx_thr;
    logic       tx_pk_en;
    pack_mode_e tx_pk;
    logic       rx_pk_en;
    pack_mode_e rx_pk;
  } ctrl_t;

  function automatic ctrl_t word_to_ctrl(input logic [BUS_W-1:0] w);
    ctrl_t c;
    c.tx_en    = w[31];
    c.rx_en    = w[30];
    c.loopback = w[29];
    c.tx_thr   = w[23:16];
    c.rx_thr   = w[15:8];
    c.tx_pk_en = w[6];
    c.tx_pk    = pack_mode_e'(w[5:4]);
    c.rx_pk_en = w[2];
    c.rx_pk    = pack_mode_e'(w[1:0]);
    return c;
  endfunction

  function automatic logic [BUS_W-1:0] ctrl_to_word(input ctrl_t c);
    logic [BUS_W-1:0] w;
    w        = '0;
    w[31]    = c.tx_en;
    w[30]    = c.rx_en;
    w[29]    = c.loopback;
    w[23:16] = c.tx_thr;
    w[15:8]  = c.rx_thr;
    w[6]     = c.tx_pk_en;
    w[5:4]   = c.tx_pk;
    w[2]     = c.rx_pk_en;
    w[1:0]   = c.rx_pk;
    return w;
  endfunction

  // Index of the last sample lane in a word for a given packing setting.
  function automatic logic [1:0] last_lane(input logic en, input pack_mode_e m);
    if (!en) return 2'd0;
    case (m)
      PK_BYTE: return 2'd3;
      PK_HALF: return 2'd1;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/pdc_fifo.sv
module pdc_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          wr_ok, rd_ok;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign wr_ok = push && !full && !flush;
  assign rd_ok = pop && !empty && !flush;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_ok) rdata <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
      if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> (count == $past(count)));
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
endmodule

// File: rtl/pdc_unpack.sv
module pdc_unpack
  import pdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             enable,
  input  logic             pk_en,
  input  pack_mode_e       pk_mode,
  input  logic             fifo_empty,
  output logic             fifo_pop,
  input  logic [BUS_W-1:0] fifo_rdata,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BUS_W-1:0] out_data
);
  logic             hold_v, fetch_p;
  logic [BUS_W-1:0] hold_w;
  logic [1:0]       idx, last;
  logic             fire;

  assign last      = last_lane(pk_en, pk_mode);
  assign fifo_pop  = enable && !hold_v && !fetch_p && !fifo_empty && !flush;
  assign out_valid = hold_v && enable && !flush;
  assign fire      = out_valid && out_ready;

  always_comb begin
    if (!pk_en)
      out_data = hold_w;
    else if (pk_mode == PK_BYTE)
      out_data = {24'b0, hold_w[{idx, 3'b000} +: 8]};
    else if (pk_mode == PK_HALF)
      out_data = {16'b0, hold_w[{idx[0], 4'b0000} +: 16]};
    else
      out_data = hold_w;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      hold_v  <= 1'b0;
      fetch_p <= 1'b0;
      idx     <= '0;
      hold_w  <= '0;
    end else begin
      if (fifo_pop) fetch_p <= 1'b1;
      if (fetch_p) begin
        fetch_p <= 1'b0;
        hold_v  <= 1'b1;
        hold_w  <= fifo_rdata;
        idx     <= '0;
      end else if (fire) begin
        if (idx >= last) hold_v <= 1'b0;
        else             idx    <= idx + 1'b1;
      end
    end
  end

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_data));
endmodule

// File: rtl/pdc_pack.sv
module pdc_pack
  import pdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             enable,
  input  logic             pk_en,
  input  pack_mode_e       pk_mode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BUS_W-1:0] in_data,
  input  logic             fifo_full,
  output logic             fifo_push,
  output logic [BUS_W-1:0] fifo_wdata
);
  logic [BUS_W-1:0] acc, placed;
  logic [1:0]       idx, last;
  logic             take;

  assign last     = last_lane(pk_en, pk_mode);
  assign in_ready = enable && !fifo_full && !flush;
  assign take     = in_valid && in_ready;

  always_comb begin
    if (!pk_en)
      placed = in_data;
    else if (pk_mode == PK_BYTE)
      placed = {24'b0, in_data[7:0]} << {idx, 3'b000};
    else if (pk_mode == PK_HALF)
      placed = {16'b0, in_data[15:0]} << {idx[0], 4'b0000};
    else
      placed = in_data;
  end

  assign fifo_push  = take && (idx >= last);
  assign fifo_wdata = acc | placed;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      acc <= '0;
      idx <= '0;
    end else if (take) begin
      if (idx >= last) begin
        acc <= '0;
        idx <= '0;
      end else begin
        acc <= acc | placed;
        idx <= idx + 1'b1;
      end
    end
  end

  p_no_push_full_r10: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> !fifo_full);
  p_lane_step_r5: assert property (@(posedge clk) disable iff (rst)
    (take && !fifo_push) |=> (idx != 2'd0));
endmodule

// File: rtl/pack_dma_chan.sv
module pack_dma_chan
  import pdc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              strm_tx_valid,
  input  logic              strm_tx_ready,
  output logic [BUS_W-1:0]  strm_tx_data,
  input  logic              strm_rx_valid,
  output logic              strm_rx_ready,
  input  logic [BUS_W-1:0]  strm_rx_data,
  output logic              tx_dma_req,
  output logic              rx_dma_req
);
  ctrl_t            ctrl_q;
  logic             tx_flush, rx_flush;
  logic             txf_pop, txf_full, txf_empty;
  logic [BUS_W-1:0] txf_q;
  logic [CW-1:0]    txf_cnt;
  logic             rxf_push, rxf_full, rxf_empty, rxf_pop;
  logic [BUS_W-1:0] rxf_d, rxf_q;
  logic [CW-1:0]    rxf_cnt;
  logic             tx_ov, tx_or, rx_iv, rx_ir;
  logic [BUS_W-1:0] tx_od, rx_id;
  logic [7:0]       tx_free, rx_free, rx_fill;
  logic [BUS_W-1:0] stat_w, rd_word;
  logic             rd_from_fifo, rd_hit;

  assign tx_flush = bus_wr && (bus_addr == OFS_CLEAR) && bus_wdata[31];
  assign rx_flush = bus_wr && (bus_addr == OFS_CLEAR) && bus_wdata[30];
  assign rxf_pop  = bus_rd && (bus_addr == OFS_RXD);

  always_ff @(posedge clk) begin
    if (rst)                                ctrl_q <= '0;
    else if (bus_wr && bus_addr == OFS_CTRL) ctrl_q <= word_to_ctrl(bus_wdata);
  end

  pdc_fifo #(.DEPTH(DEPTH), .W(BUS_W)) u_txf (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .push(bus_wr && bus_addr == OFS_TXD), .wdata(bus_wdata),
    .pop(txf_pop), .rdata(txf_q), .count(txf_cnt),
    .full(txf_full), .empty(txf_empty)
  );

  pdc_unpack u_unpack (
    .clk(clk), .rst(rst), .flush(tx_flush), .enable(ctrl_q.tx_en),
    .pk_en(ctrl_q.tx_pk_en), .pk_mode(ctrl_q.tx_pk),
    .fifo_empty(txf_empty), .fifo_pop(txf_pop), .fifo_rdata(txf_q),
    .out_valid(tx_ov), .out_ready(tx_or), .out_data(tx_od)
  );

  // Loopback steers the transmit samples into the receive packer.
  assign tx_or         = ctrl_q.loopback ? rx_ir : strm_tx_ready;
  assign rx_iv         = ctrl_q.loopback ? tx_ov : strm_rx_valid;
  assign rx_id         = ctrl_q.loopback ? tx_od : strm_rx_data;
  assign strm_tx_valid = tx_ov && !ctrl_q.loopback;
  assign strm_tx_data  = tx_od;
  assign strm_rx_ready = rx_ir && !ctrl_q.loopback;

  pdc_pack u_pack (
    .clk(clk), .rst(rst), .flush(rx_flush), .enable(ctrl_q.rx_en),
    .pk_en(ctrl_q.rx_pk_en), .pk_mode(ctrl_q.rx_pk),
    .in_valid(rx_iv), .in_ready(rx_ir), .in_data(rx_id),
    .fifo_full(rxf_full), .fifo_push(rxf_push), .fifo_wdata(rxf_d)
  );

  pdc_fifo #(.DEPTH(DEPTH), .W(BUS_W)) u_rxf (
    .clk(clk), .rst(rst), .flush(rx_flush),
    .push(rxf_push), .wdata(rxf_d),
    .pop(rxf_pop), .rdata(rxf_q), .count(rxf_cnt),
    .full(rxf_full), .empty(rxf_empty)
  );

  assign tx_free    = 8'(DEPTH) - 8'(txf_cnt);
  assign rx_free    = 8'(DEPTH) - 8'(rxf_cnt);
  assign rx_fill    = 8'(rxf_cnt);
  assign tx_dma_req = (tx_free >= ctrl_q.tx_thr);
  assign rx_dma_req = (rx_fill >= ctrl_q.rx_thr);
  assign stat_w     = {tx_free, rx_free, 14'b0, tx_dma_req, rx_dma_req};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_word      <= '0;
      rd_from_fifo <= 1'b0;
      rd_hit       <= 1'b0;
    end else begin
      rd_from_fifo <= 1'b0;
      if (bus_rd) begin
        case (bus_addr)
          OFS_CTRL: rd_word <= ctrl_to_word(ctrl_q);
          OFS_STAT: rd_word <= stat_w;
          OFS_RXD: begin
            rd_from_fifo <= 1'b1;
            rd_hit       <= !rxf_empty;
            rd_word      <= '0;
          end
          default:  rd_word <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = (rd_from_fifo && rd_hit) ? rxf_q : rd_word;

  p_rd_empty_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFS_RXD && rxf_empty) |=> (bus_rdata == '0));
  p_ctrl_kept_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_CLEAR) |=> $stable(ctrl_q));
endmodule

// File: tb/test_pack_dma_chan.sv
module test_pack_dma_chan;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        strm_tx_valid, strm_tx_ready = 1'b0;
  logic [31:0] strm_tx_data;
  logic        strm_rx_valid = 1'b0, strm_rx_ready;
  logic [31:0] strm_rx_data = '0;
  logic        tx_dma_req, rx_dma_req;

  int vectors = 0, fails = 0, cyc = 0, lb_leak = 0;
  logic lb_phase = 1'b0;
  logic [31:0] got[$];

  always #10 clk = ~clk;

  pack_dma_chan #(.DEPTH(DEPTH)) i_pack_dma_chan (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .strm_tx_valid(strm_tx_valid), .strm_tx_ready(strm_tx_ready),
    .strm_tx_data(strm_tx_data), .strm_rx_valid(strm_rx_valid),
    .strm_rx_ready(strm_rx_ready), .strm_rx_data(strm_rx_data),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
  );

  always @(negedge clk) begin
    if (strm_tx_valid && strm_tx_ready) got.push_back(strm_tx_data);
    if (lb_phase && strm_tx_valid) lb_leak++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic send_rx(input logic [31:0] s);
    logic acc;
    int guard;
    @(posedge clk); #1;
    strm_rx_valid = 1'b1; strm_rx_data = s;
    acc = 1'b0; guard = 0;
    while (!acc && guard < 50) begin
      @(negedge clk); acc = strm_rx_ready;
      @(posedge clk); #1;
      guard++;
    end
    strm_rx_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] ctrlw(input int txe, rxe, lb, tthr, rthr,
                                        tpe, tpm, rpe, rpm);
    ctrlw = (32'(txe) << 31) | (32'(rxe) << 30) | (32'(lb) << 29) |
            ((32'(tthr) & 32'hFF) << 16) | ((32'(rthr) & 32'hFF) << 8) |
            (32'(tpe) << 6) | ((32'(tpm) & 3) << 4) | (32'(rpe) << 2) | (32'(rpm) & 3);
  endfunction

  function automatic logic [31:0] stat(input int tf, rf, tt, rt);
    int tfree;
    tfree = DEPTH - tf;
    stat = (32'(tfree) << 24) | (32'(DEPTH - rf) << 16) |
           (32'(tfree >= tt) << 1) | 32'(rf >= rt);
  endfunction

  initial begin
    logic [31:0] d, w;
    int txthr[5] = '{0, 1, 9, 16, 17};
    int rxthr[4] = '{0, 1, 7, 16};

    idle(3);
    rst = 1'b0;
    idle(2);

    // R12: reset state
    rd(5'h00, d); chk("R12 ctrl", d, 32'h0);
    rd(5'h08, d); chk("R12 status", d, 32'h1010_0003);
    chk("R12 tx valid", 32'(strm_tx_valid), 0);
    chk("R12 rx ready", 32'(strm_rx_ready), 0);

    // R1: control field layout
    wr(5'h00, 32'h1F00_0088); rd(5'h00, d); chk("R1 undefined bits", d, 32'h0);
    wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, d); chk("R1 all fields", d, 32'hE0FF_FF77);
    wr(5'h00, 32'h2012_3445); rd(5'h00, d); chk("R1 mixed", d, 32'h2012_3445 & 32'hE0FF_FF77);
    wr(5'h00, 32'h0);

    // R7 R8 R10 R11: transmit fill sweep with transmit disabled
    foreach (txthr[t]) begin
      wr(5'h00, ctrlw(0, 0, 0, txthr[t], 0, 0, 0, 0, 0));
      wr(5'h04, 32'h8000_0000);
      for (int k = 0; k <= DEPTH; k++) begin
        rd(5'h08, d);
        chk("R7 R8 tx sweep", d, stat(k, 0, txthr[t], 0));
        chk("R8 tx_dma_req", 32'(tx_dma_req), 32'((DEPTH - k) >= txthr[t]));
        wr(5'h0C, 32'hC000_0000 | (32'(txthr[t]) << 8) | 32'(k));
      end
      rd(5'h08, d);
      chk("R10 tx full write dropped", d[31:24], 0);
      chk("R11 tx disabled idle", 32'(strm_tx_valid), 0);
    end
    // R2: drain the full FIFO, unpacked
    got.delete();
    strm_tx_ready = 1'b1;
    wr(5'h00, ctrlw(1, 0, 0, 0, 0, 0, 0, 0, 0));
    idle(80);
    chk("R2 count", got.size(), DEPTH);
    for (int k = 0; k < DEPTH && k < got.size(); k++)
      chk("R2 order", got[k], 32'hC000_1100 | 32'(k));

    // R3: 16-bit unpacking
    got.delete();
    wr(5'h00, ctrlw(1, 0, 0, 0, 0, 1, 3, 0, 0));
    wr(5'h0C, 32'h8765_4321); wr(5'h0C, 32'h0FED_CBA9);
    idle(20);
    chk("R3 count", got.size(), 4);
    if (got.size() == 4) begin
      chk("R3 s0", got[0], 32'h4321); chk("R3 s1", got[1], 32'h8765);
      chk("R3 s2", got[2], 32'hCBA9); chk("R3 s3", got[3], 32'h0FED);
    end
    // R4: 8-bit unpacking
    got.delete();
    wr(5'h00, ctrlw(1, 0, 0, 0, 0, 1, 2, 0, 0));
    wr(5'h0C, 32'h0403_0201); wr(5'h0C, 32'h8877_6655);
    idle(24);
    chk("R4 count", got.size(), 8);
    for (int i = 0; i < 8 && i < got.size(); i++) begin
      w = (i < 4) ? 32'h0403_0201 : 32'h8877_6655;
      chk("R4 byte", got[i], (w >> (8 * (i % 4))) & 32'hFF);
    end
    // R2: mode 2 with pack enable clear stays unpacked
    got.delete();
    wr(5'h00, ctrlw(1, 0, 0, 0, 0, 0, 2, 0, 0));
    wr(5'h0C, 32'hDEAD_BEEF);
    idle(10);
    chk("R2 pack off count", got.size(), 1);
    if (got.size() == 1) chk("R2 pack off word", got[0], 32'hDEAD_BEEF);

    // R3 R9: stall then drop a partly sent word
    strm_tx_ready = 1'b0;
    got.delete();
    wr(5'h00, ctrlw(1, 0, 0, 0, 0, 1, 2, 0, 0));
    wr(5'h0C, 32'hDDCC_BBAA);
    idle(5);
    chk("R3 stall valid", 32'(strm_tx_valid), 1);
    chk("R3 stall data", strm_tx_data, 32'hAA);
    wr(5'h04, 32'h8000_0000);
    chk("R9 tx flush drops held", 32'(strm_tx_valid), 0);
    rd(5'h00, d); chk("R9 ctrl unchanged", d, ctrlw(1, 0, 0, 0, 0, 1, 2, 0, 0));
    wr(5'h0C, 32'h4433_2211);
    strm_tx_ready = 1'b1;
    idle(15);
    chk("R9 after flush count", got.size(), 4);
    for (int i = 0; i < 4 && i < got.size(); i++)
      chk("R9 after flush byte", got[i], 32'(8'h11 * (i + 1)));
    wr(5'h00, 32'h0);

    // R7 R8 R10: receive fill sweep, unpacked
    foreach (rxthr[t]) begin
      wr(5'h00, ctrlw(0, 1, 0, 0, rxthr[t], 0, 0, 0, 0));
      wr(5'h04, 32'h4000_0000);
      for (int k = 0; k < DEPTH; k++) begin
        rd(5'h08, d);
        chk("R7 R8 rx sweep", d, stat(0, k, 0, rxthr[t]));
        chk("R8 rx_dma_req", 32'(rx_dma_req), 32'(k >= rxthr[t]));
        send_rx(32'h5A00_0000 | (32'(rxthr[t]) << 8) | 32'(k));
      end
      rd(5'h08, d);
      chk("R7 R8 rx full", d, stat(0, DEPTH, 0, rxthr[t]));
      chk("R10 rx full stalls", 32'(strm_rx_ready), 0);
    end
    for (int k = 0; k < DEPTH; k++) begin
      rd(5'h10, d);
      chk("R5 rx order", d, 32'h5A00_1000 | 32'(k));
    end
    rd(5'h10, d); chk("R10 empty read", d, 0);
    rd(5'h08, d); chk("R10 empty read no change", d, stat(0, 0, 0, 16));

    // R5: 16-bit and 8-bit packing
    wr(5'h00, ctrlw(0, 1, 0, 0, 0, 0, 0, 1, 3));
    for (int i = 0; i < 4; i++) send_rx(32'hABC0_0000 | 32'(16'h1111 * (i + 1)));
    rd(5'h10, d); chk("R5 half w0", d, 32'h2222_1111);
    rd(5'h10, d); chk("R5 half w1", d, 32'h4444_3333);
    wr(5'h00, ctrlw(0, 1, 0, 0, 0, 0, 0, 1, 2));
    for (int i = 0; i < 8; i++) send_rx(32'h0000_0F00 | 32'(8'h10 + i));
    rd(5'h10, d); chk("R5 byte w0", d, 32'h1312_1110);
    rd(5'h10, d); chk("R5 byte w1", d, 32'h1716_1514);
    wr(5'h00, ctrlw(0, 1, 0, 0, 0, 0, 0, 0, 2));
    send_rx(32'hFACE_0001);
    rd(5'h10, d); chk("R5 pack off", d, 32'hFACE_0001);

    // R9: receive flush drops partial word, transmit side untouched
    wr(5'h00, ctrlw(0, 1, 0, 0, 0, 0, 0, 1, 2));
    wr(5'h0C, 32'h1); wr(5'h0C, 32'h2);
    send_rx(32'hEE); send_rx(32'hFF);
    wr(5'h04, 32'h4000_0000);
    rd(5'h08, d); chk("R9 rx flush, tx kept", d, stat(2, 0, 0, 0));
    for (int i = 0; i < 4; i++) send_rx(32'(8'hA0 + i));
    rd(5'h10, d); chk("R9 rx word after flush", d, 32'hA3A2_A1A0);
    wr(5'h04, 32'h8000_0000);

    // R11: receive disabled takes nothing
    wr(5'h00, 32'h0);
    @(posedge clk); #1; strm_rx_valid = 1'b1; strm_rx_data = 32'h77;
    idle(5);
    chk("R11 rx ready low", 32'(strm_rx_ready), 0);
    strm_rx_valid = 1'b0;
    rd(5'h08, d); chk("R11 rx nothing taken", d, stat(0, 0, 0, 0));

    // R6: loopback with 16-bit split and rejoin
    got.delete();
    strm_tx_ready = 1'b1;
    lb_phase = 1'b1;
    wr(5'h00, ctrlw(1, 1, 1, 0, 0, 1, 3, 1, 3));
    wr(5'h0C, 32'h1234_5678); wr(5'h0C, 32'h9ABC_DEF0); wr(5'h0C, 32'h0F0F_F0F0);
    idle(30);
    chk("R6 rx ready low", 32'(strm_rx_ready), 0);
    rd(5'h10, d); chk("R6 loop w0", d, 32'h1234_5678);
    rd(5'h10, d); chk("R6 loop w1", d, 32'h9ABC_DEF0);
    rd(5'h10, d); chk("R6 loop w2", d, 32'h0F0F_F0F0);
    wr(5'h00, ctrlw(1, 1, 1, 0, 0, 1, 3, 0, 0));
    wr(5'h0C, 32'hBEEF_CAFE);
    idle(15);
    rd(5'h10, d); chk("R6 loop split lo", d, 32'hCAFE);
    rd(5'h10, d); chk("R6 loop split hi", d, 32'hBEEF);
    lb_phase = 1'b0;
    chk("R6 no stream output", 32'(lb_leak), 0);
    chk("R6 nothing collected", got.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule